// File: doc/BRIEF.md
# Up/Down Interval Timer

A 32-bit counter/timer peripheral behind a simple register bus. Software programs a control word, a starting count and a compare/reload word. Once enabled, the engine adds one or subtracts one on every clock. An up count ends when it equals the compare/reload word. A down count ends when it reaches zero. When the count ends, the timer either stops, or reloads and carries on without a pause cycle. It raises a one-cycle interrupt pulse for each terminal event if interrupts are enabled.

Clearing the enable bit holds the count where it is, and setting it again resumes from that value. The count register can be written at any time, which resets or preloads the timer. Each bus access is a single cycle. Writes take effect at the clock edge, and read data is a combinational decode of the byte offset on the address lines.

Top module: `updn_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: The control word at offset 0x0 holds enable in bit 3, one-shot select in bit 2 (1 = stop at the end, 0 = continuous), direction in bit 1 (1 = up, 0 = down) and interrupt enable in bit 0. Bits 31:4 ignore writes and read as zero.
- R3: A read from any offset other than 0x0, 0x4 and 0x8 returns zero.
- R4: While enabled and not stopped, the count register at offset 0x4 moves by one per clock, upward or downward as the direction bit selects. It starts from whatever value the register held when enable was set.
- R5: A count is at its terminal value when it equals the compare/reload word (up) or equals zero (down).
- R6: In continuous mode, the clock that sees the terminal value loads zero (up) or the compare/reload word (down), and counting goes on in the next clock.
- R7: In one-shot mode the count stops and holds at the terminal value, with one interrupt pulse. Writing the control word with enable still set does not restart it. It restarts only after a control write with enable clear followed by re-enabling, or after a write to the count register.
- R8: `irq` is high only in a clock where the running count sits at its terminal value and interrupt enable is set. It lasts one clock per terminal event.
- R9: While enable is clear, the count register holds its value. Re-enabling resumes counting from the held value.
- R10: A bus write to the count register takes priority over the count update of the same clock.
- R11: The compare/reload word at offset 0x8 reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
Four directed patterns cover the mode and direction combinations. Continuous up counting checks reload to zero and the pulse period. Continuous down counting from a preload checks reload from the compare word. One-shot down counting checks the stop, and also that re-enabling without clearing does not restart. Counting with interrupts masked separates terminal detection from pulse gating. A disable/re-enable sequence and a write to the count register while it runs separate holding from clearing, and bus priority from counting. A long run of seeded random register writes with small values then drives the timer through many terminal events. Every clock of that run is compared against a cycle model in the bench, which catches errors in decode, priority and the stop flag under mixed orderings.

// File: rtl/updn_timer_pkg.sv
// Shared types and register layout for the up/down interval timer.
// Assumes byte offsets on the bus and one register word per offset.
package updn_timer_pkg;

    // Control word fields; packed order places en at bit 3, ie at bit 0
    typedef struct packed {
        logic en;
        logic oneshot;
        logic up;
        logic ie;
    } tmr_cfg_t;

    localparam int CFG_BITS = $bits(tmr_cfg_t);
    localparam int EN_BIT   = 3;

    localparam int unsigned OFS_CFG  = 32'h0;
    localparam int unsigned OFS_VAL  = 32'h4;
    localparam int unsigned OFS_DATA = 32'h8;

endpackage

// File: rtl/updn_timer_regs.sv
// Register decode for the timer: holds the control word and the
// compare/reload word, raises write strobes for the count engine and
// builds the read data. Assumes single-cycle bus writes.
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    output tmr_cfg_t          cfg_o,
    output logic [CNT_W-1:0]  data_o,
    output logic              val_wr_o,
    output logic              stop_clr_o,
    output logic [CNT_W-1:0]  bus_rdata
);

    logic sel_cfg;
    logic sel_val;
    logic sel_data;

    // Address decode of the three mapped offsets
    always_comb begin
        sel_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
        sel_val  = (bus_addr == ADDR_W'(OFS_VAL));
        sel_data = (bus_addr == ADDR_W'(OFS_DATA));
    end

    // Write strobes handed to the count engine
    always_comb begin
        val_wr_o   = bus_we && sel_val;
        stop_clr_o = bus_we && sel_cfg && !bus_wdata[EN_BIT];
    end

    // Control word register; upper write bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= '0;
        else if (bus_we && sel_cfg)
            cfg_o <= tmr_cfg_t'(bus_wdata[CFG_BITS-1:0]);
    end

    // Compare/reload word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_o <= '0;
        else if (bus_we && sel_data)
            data_o <= bus_wdata;
    end

    // Read mux; unmapped offsets and unused control bits return zero
    always_comb begin
        bus_rdata = '0;
        if (sel_cfg)
            bus_rdata[CFG_BITS-1:0] = cfg_o;
        else if (sel_val)
            bus_rdata = cnt_i;
        else if (sel_data)
            bus_rdata = data_o;
    end

endmodule

// File: rtl/updn_timer_core.sv
// Count engine: steps the count, detects the terminal value, reloads
// or stops, and produces the interrupt pulse. A bus write of the count
// overrides the step of the same clock and clears the stop flag.
module updn_timer_core
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_cfg_t         cfg_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             val_wr_i,
    input  logic             stop_clr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o,
    output logic             irq_o
);

    logic             running;
    logic             at_term;
    logic             term_hit;
    logic [CNT_W-1:0] cnt_nxt;
    logic             done_nxt;

    // Terminal detection on the present count
    always_comb begin
        running  = cfg_i.en && !done_o;
        at_term  = cfg_i.up ? (cnt_o == data_i) : (cnt_o == '0);
        term_hit = running && at_term;
        irq_o    = term_hit && cfg_i.ie;
    end

    // Next count: bus write first, then reload/stop, then step
    always_comb begin
        cnt_nxt = cnt_o;
        if (val_wr_i)
            cnt_nxt = wdata_i;
        else if (term_hit) begin
            if (!cfg_i.oneshot)
                cnt_nxt = cfg_i.up ? '0 : data_i;
        end else if (running)
            cnt_nxt = cfg_i.up ? cnt_o + 1'b1 : cnt_o - 1'b1;
    end

    // Stop flag: set by a one-shot end, cleared by software
    always_comb begin
        done_nxt = done_o;
        if (val_wr_i || stop_clr_i)
            done_nxt = 1'b0;
        else if (term_hit && cfg_i.oneshot)
            done_nxt = 1'b1;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            done_o <= 1'b0;
        end else begin
            cnt_o  <= cnt_nxt;
            done_o <= done_nxt;
        end
    end

endmodule

// File: rtl/updn_timer.sv
// Top of the up/down interval timer: register decode plus count engine.
// Assumes a single-cycle register bus with combinational read data.
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] data_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             val_wr;
    logic             stop_clr;

    updn_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .cnt_i      (cnt_q),
        .cfg_o      (cfg_q),
        .data_o     (data_q),
        .val_wr_o   (val_wr),
        .stop_clr_o (stop_clr),
        .bus_rdata  (bus_rdata)
    );

    updn_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg_q),
        .data_i     (data_q),
        .val_wr_i   (val_wr),
        .stop_clr_i (stop_clr),
        .wdata_i    (bus_wdata),
        .cnt_o      (cnt_q),
        .done_o     (done_q),
        .irq_o      (irq)
    );

endmodule

// File: rtl/updn_timer_chk.sv
// Property checker for the timer, bound to the top module. Relates bus
// activity, the register state and the interrupt over time.
module updn_timer_chk
    import updn_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              irq,
    input tmr_cfg_t          cfg,
    input logic [CNT_W-1:0]  data_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              done_q
);

    logic val_wr;
    logic cfg_wr;

    // Bus write qualifiers seen from the ports
    always_comb begin
        val_wr = bus_we && (bus_addr == ADDR_W'(OFS_VAL));
        cfg_wr = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
    end

    AST_CFG_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CFG)) |-> (bus_rdata[CNT_W-1:CFG_BITS] == '0)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(OFS_CFG) && bus_addr != ADDR_W'(OFS_VAL) &&
         bus_addr != ADDR_W'(OFS_DATA)) |-> (bus_rdata == '0)); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !done_q && cfg.up && cnt_q != data_q && !val_wr)
        |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

    AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !done_q && cfg.up && !cfg.oneshot && cnt_q == data_q && !val_wr)
        |=> (cnt_q == '0)); // R6

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg.oneshot && !val_wr && !cfg_wr) |=> (!irq && $stable(cnt_q))); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg.ie); // R8

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && !val_wr) |=> $stable(cnt_q)); // R9

    AST_VALUE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr |=> (cnt_q == $past(bus_wdata))); // R10

endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .cfg       (cfg_q),
    .data_q    (data_q),
    .cnt_q     (cnt_q),
    .done_q    (done_q)
);

// File: tb/updn_timer_test.sv
// Bench for the interval timer: directed mode scenarios followed by a
// seeded random register-write run, all compared each clock against a
// cycle model built from the requirements.
module updn_timer_test;

    localparam int CW = 32;
    localparam int AW = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic          we    = 1'b0;
    logic [CW-1:0] wd    = '0;
    wire  [CW-1:0] rd;
    wire           irq;

    int n_chk  = 0;
    int n_fail = 0;
    int n_irq  = 0;

    // Model state
    logic [3:0]    m_cfg  = '0;
    logic [CW-1:0] m_cnt  = '0;
    logic [CW-1:0] m_data = '0;
    logic          m_done = 1'b0;

    always #4 clk = ~clk;

    updn_timer #(.CNT_W(CW), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wd),
        .bus_rdata (rd),
        .irq       (irq)
    );

    function automatic logic m_term();
        return m_cfg[3] && !m_done && (m_cfg[1] ? (m_cnt == m_data) : (m_cnt == '0));
    endfunction

    function automatic logic [CW-1:0] m_read(logic [AW-1:0] a);
        case (a)
            4'h0:    return {28'd0, m_cfg};
            4'h4:    return m_cnt;
            4'h8:    return m_data;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        case (a)
            4'h0:    return "R2";
            4'h4:    return "R4";
            4'h8:    return "R11";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One bus clock: drive, compare read data and irq, then advance the model
    task automatic cyc(logic w, logic [AW-1:0] a, logic [CW-1:0] d);
        logic          t;
        logic [CW-1:0] nc;
        logic          nd;
        we = w; addr = a; wd = d;
        #1;
        t = m_term();
        check(tag_of(a), rd, m_read(a));
        check("R8", {31'd0, irq}, {31'd0, t && m_cfg[0]});
        if (irq) n_irq++;
        @(posedge clk);
        nc = m_cnt;
        nd = m_done;
        if (w && a == 4'h4) nc = d;
        else if (t) begin
            if (!m_cfg[2]) nc = m_cfg[1] ? '0 : m_data;
        end else if (m_cfg[3] && !m_done)
            nc = m_cfg[1] ? m_cnt + 1 : m_cnt - 1;
        if ((w && a == 4'h4) || (w && a == 4'h0 && !d[3])) nd = 1'b0;
        else if (t && m_cfg[2]) nd = 1'b1;
        if (w && a == 4'h0) m_cfg  = d[3:0];
        if (w && a == 4'h8) m_data = d;
        m_cnt  = nc;
        m_done = nd;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'h4, '0);
    endtask

    task automatic peek(logic [AW-1:0] a, output logic [CW-1:0] v);
        we = 1'b0; addr = a;
        #1;
        v = rd;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [CW-1:0] v;
        int            base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 16; a += 4) begin
            peek(AW'(a), v);
            check("R1", v, '0);
        end
        check("R1", {31'd0, irq}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: continuous up, compare 3 -> period of 4, one pulse each
        cyc(1'b1, 4'h8, 32'd3);
        cyc(1'b1, 4'h0, 32'hB);
        base = n_irq;
        idle(12);
        check("R6", n_irq - base, 3);

        // R9: disable holds, re-enable resumes
        cyc(1'b1, 4'h0, 32'h0);
        idle(5);
        peek(4'h4, v);
        check("R9", v, 32'd1);
        cyc(1'b1, 4'h0, 32'hB);
        idle(2);
        peek(4'h4, v);
        check("R9", v, 32'd3);

        // R7: one-shot down from 5, stops at zero with one pulse
        cyc(1'b1, 4'h0, 32'h0);
        cyc(1'b1, 4'h4, 32'd5);
        cyc(1'b1, 4'h8, 32'd9);
        cyc(1'b1, 4'h0, 32'hD);
        base = n_irq;
        idle(15);
        peek(4'h4, v);
        check("R7", v, '0);
        check("R7", n_irq - base, 1);
        // R7: rewrite with enable kept set does not restart
        cyc(1'b1, 4'h0, 32'hD);
        idle(5);
        check("R7", n_irq - base, 1);
        // R7: clear then set enable restarts (zero is terminal at once)
        cyc(1'b1, 4'h0, 32'h0);
        cyc(1'b1, 4'h0, 32'hD);
        idle(5);
        check("R7", n_irq - base, 2);

        // R6: continuous down from 2 reloads compare 4
        cyc(1'b1, 4'h0, 32'h0);
        cyc(1'b1, 4'h4, 32'd2);
        cyc(1'b1, 4'h8, 32'd4);
        cyc(1'b1, 4'h0, 32'h9);
        base = n_irq;
        idle(13);
        check("R6", n_irq - base, 3);
        peek(4'h4, v);
        check("R5", v, 32'd4);

        // R8: interrupt masked, no pulses while counting continues
        cyc(1'b1, 4'h0, 32'h0);
        cyc(1'b1, 4'h4, 32'd0);
        cyc(1'b1, 4'h8, 32'd2);
        cyc(1'b1, 4'h0, 32'hA);
        base = n_irq;
        idle(20);
        check("R8", n_irq - base, 0);

        // R10: write of the count while running wins over the step
        cyc(1'b1, 4'h0, 32'hB);
        cyc(1'b1, 4'h4, 32'd100);
        peek(4'h4, v);
        check("R10", v, 32'd100);

        // R2: upper control bits ignored
        cyc(1'b1, 4'h0, 32'hFFFF_FFF0);
        peek(4'h0, v);
        check("R2", v, '0);
        cyc(1'b1, 4'h0, 32'hFFFF_FFF5);
        peek(4'h0, v);
        check("R2", v, 32'h5);

        // R3 and R11: unmapped offsets and compare word readback
        peek(4'hC, v);
        check("R3", v, '0);
        peek(4'h2, v);
        check("R3", v, '0);
        cyc(1'b1, 4'h8, 32'hDEAD_BEEF);
        peek(4'h8, v);
        check("R11", v, 32'hDEAD_BEEF);

        // Random register traffic with small values
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            logic [CW-1:0] d;
            case ($urandom_range(0, 4))
                0:       a = 4'h0;
                1:       a = 4'h4;
                2:       a = 4'h8;
                3:       a = 4'hC;
                default: a = AW'($urandom_range(0, 15));
            endcase
            if (a == 4'h0) d = {$urandom_range(0, 255), 4'(($urandom_range(0, 15)) | 8)};
            else           d = CW'($urandom_range(0, 20));
            if ($urandom_range(0, 9) == 0) cyc(1'b1, a, d);
            else                           cyc(1'b0, a, '0);
        end

        finish_run();
    end

endmodule